// File: doc/BRIEF.md
# Latched Interrupt and FIFO Flag Status Register

This block collects interrupt events for a data acquisition controller and presents them to software as one 16-bit status word. Single-cycle pulses from the converter datapath are captured in sticky bits. These sources are DAC FIFO half-full, end of acquisition, end of burst, ADC FIFO not-empty, DAC FIFO empty and a selectable general source. The same word also carries two live ADC FIFO flags that are copied straight from their inputs. An asynchronous external request line is synchronized, and it latches only on its rising edge. ADC half-full is derived inside the block by comparing an ADC FIFO sample count against a threshold.

Software reads either the status word or an interrupt enable mask through a strobed read port. It clears sticky bits by writing ones to the status address, and a clear needs no follow-up write. A single request output is raised whenever any enabled sticky bit is set. The external edge detector is a two-state machine with the states XE_LOW (synchronized input seen low) and XE_HIGH (synchronized input seen high). Its transitions are XE_LOW to XE_HIGH when the synchronized input is high, which is the only transition that produces an edge event, and XE_HIGH to XE_LOW when the input is low.

Top module: `irq_status_reg`

## Requirements
- R1: Status word layout: bit 5 DAC half-full, 6 end of acquisition, 7 general, 8 external, 9 end of burst, 10 ADC half-full, 11 ADC not-empty event, 12 live ADC not-empty, 13 live ADC full, 14 DAC empty; bits 0 to 4 and bit 15 always read 0.
- R2: A write with reg_sel=0 clears each sticky bit whose reg_wdata bit is 1; bits written 0 keep their value, and a clear takes effect once with no need to write the bit back to 0.
- R3: When a source event and a clear of the same bit fall in the same cycle, the bit ends set.
- R4: ext_irq_in passes through a two-flop synchronizer; bit 8 latches on a low-to-high transition only, and a line held high does not set it again after a clear.
- R5: ev_burst_done sets bit 8+1 (bit 9) only while burst_en is 1; with burst_en=0 it has no effect.
- R6: Bit 10 is set in every cycle in which adc_level is greater than HF_LIMIT (default 255): a level of 256 sets it and 255 does not; while the level stays above the limit a clear does not remove it.
- R7: gen_sel chooses the general source for bit 7: 0 none, 1 gen_src[0], 2 gen_src[1], 3 either gen_src bit.
- R8: Bits 12 and 13 follow adc_nempty and adc_full and are not changed by clear writes.
- R9: A write with reg_sel=1 loads the enable mask (only the sticky positions are kept and read back); irq_req is 1 exactly when some sticky bit and its enable bit are both 1, and it drops only after a write.
- R10: A synchronous active-high rst clears all sticky bits, the enable mask, the synchronizer and reg_rdata.
- R11: reg_rdata takes the word chosen by reg_sel in the cycle after reg_rd is 1, and holds its value while reg_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 status, 1 enable mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data: clear mask or enable mask |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| burst_en | input | 1 | ADC burst mode enable |
| gen_sel | input | 2 | General interrupt source select |
| gen_src | input | 2 | General interrupt source pulses |
| ev_dac_half | input | 1 | DAC FIFO half-full pulse |
| ev_acq_done | input | 1 | End-of-acquisition pulse |
| ev_burst_done | input | 1 | End-of-burst pulse |
| ev_adc_nempty | input | 1 | ADC FIFO not-empty event pulse |
| ev_dac_empty | input | 1 | DAC FIFO empty pulse |
| ext_irq_in | input | 1 | Asynchronous external request line |
| adc_level | input | CNT_W | ADC FIFO sample count |
| adc_nempty | input | 1 | Live ADC FIFO not-empty flag |
| adc_full | input | 1 | Live ADC FIFO full flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Single-source pulses show that each event lands on its own bit and nowhere else. Mixed random pulses with random clear masks test that set and clear act on each bit separately and that a set wins when both occur in the same cycle. The external line is raised, held and dropped, which separates edge capture from level capture and shows the synchronizer delay. The ADC count is swept across 255 and 256 to fix the threshold, and every select and burst-mode value is paired with active sources so that gated and ungated paths can be told apart.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int WORD_W = 16;

    localparam int B_DAC_HALF  = 5;
    localparam int B_ACQ_DONE  = 6;
    localparam int B_GEN       = 7;
    localparam int B_EXT       = 8;
    localparam int B_BURST     = 9;
    localparam int B_ADC_HALF  = 10;
    localparam int B_ADC_NE_EV = 11;
    localparam int B_ADC_NE    = 12;
    localparam int B_ADC_FULL  = 13;
    localparam int B_DAC_EMPTY = 14;

    localparam logic [WORD_W-1:0] STICKY_MASK =
        (WORD_W'(1) << B_DAC_HALF)  | (WORD_W'(1) << B_ACQ_DONE) |
        (WORD_W'(1) << B_GEN)       | (WORD_W'(1) << B_EXT)      |
        (WORD_W'(1) << B_BURST)     | (WORD_W'(1) << B_ADC_HALF) |
        (WORD_W'(1) << B_ADC_NE_EV) | (WORD_W'(1) << B_DAC_EMPTY);

    typedef enum logic {XE_LOW, XE_HIGH} ext_state_t;

    typedef enum logic [1:0] {
        GEN_OFF    = 2'd0,
        GEN_SRC0   = 2'd1,
        GEN_SRC1   = 2'd2,
        GEN_EITHER = 2'd3
    } gen_sel_t;
endpackage

// File: rtl/irq_ext_edge.sv
module irq_ext_edge
    import irq_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   synced;
    ext_state_t             state_q, state_d;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign synced = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) state_q <= XE_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            XE_LOW: begin
                if (synced) begin
                    state_d = XE_HIGH;
                    rise    = 1'b1;
                end
            end
            XE_HIGH: begin
                if (!synced) state_d = XE_LOW;
            end
            default: state_d = XE_LOW;
        endcase
    end
endmodule

// File: rtl/irq_gen_select.sv
module irq_gen_select
    import irq_stat_pkg::*;
#(
    parameter int SRC_N = 2
) (
    input  logic [1:0]       sel,
    input  logic [SRC_N-1:0] src,
    output logic             hit
);
    gen_sel_t mode;
    assign mode = gen_sel_t'(sel);

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            GEN_OFF:    hit = 1'b0;
            GEN_SRC0:   hit = src[0];
            GEN_SRC1:   hit = src[1];
            GEN_EITHER: hit = |src;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) q[i] <= 1'b0;
                else     q[i] <= set_vec[i] | (q[i] & ~clr_vec[i]);
            end
        end
    endgenerate
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_stat_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int HF_LIMIT    = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [15:0]       reg_rdata,
    input  logic              burst_en,
    input  logic [1:0]        gen_sel,
    input  logic [1:0]        gen_src,
    input  logic              ev_dac_half,
    input  logic              ev_acq_done,
    input  logic              ev_burst_done,
    input  logic              ev_adc_nempty,
    input  logic              ev_dac_empty,
    input  logic              ext_irq_in,
    input  logic [CNT_W-1:0]  adc_level,
    input  logic              adc_nempty,
    input  logic              adc_full,
    output logic              irq_req
);
    localparam logic [CNT_W-1:0] HF_CMP = CNT_W'(HF_LIMIT);

    logic              ext_rise;
    logic              gen_hit;
    logic              adc_half;
    logic [WORD_W-1:0] ev_vec;
    logic [WORD_W-1:0] clr_vec;
    logic [WORD_W-1:0] lat_q;
    logic [WORD_W-1:0] en_q;
    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] rd_word;

    irq_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_irq_in),
        .rise     (ext_rise)
    );

    irq_gen_select #(.SRC_N(2)) u_gen (
        .sel (gen_sel),
        .src (gen_src),
        .hit (gen_hit)
    );

    assign adc_half = (adc_level > HF_CMP);

    always_comb begin
        ev_vec              = '0;
        ev_vec[B_DAC_HALF]  = ev_dac_half;
        ev_vec[B_ACQ_DONE]  = ev_acq_done;
        ev_vec[B_GEN]       = gen_hit;
        ev_vec[B_EXT]       = ext_rise;
        ev_vec[B_BURST]     = ev_burst_done & burst_en;
        ev_vec[B_ADC_HALF]  = adc_half;
        ev_vec[B_ADC_NE_EV] = ev_adc_nempty;
        ev_vec[B_DAC_EMPTY] = ev_dac_empty;
    end

    assign clr_vec = (reg_wr && !reg_sel) ? (reg_wdata & STICKY_MASK) : '0;

    irq_latch_bank #(.W(WORD_W)) u_lat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (ev_vec),
        .clr_vec (clr_vec),
        .q       (lat_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                   en_q <= '0;
        else if (reg_wr && reg_sel) en_q <= reg_wdata & STICKY_MASK;
    end

    always_comb begin
        status_word             = lat_q & STICKY_MASK;
        status_word[B_ADC_NE]   = adc_nempty;
        status_word[B_ADC_FULL] = adc_full;
    end

    assign rd_word = reg_sel ? en_q : status_word;

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    assign irq_req = |(lat_q & en_q);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_stat_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_sel,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic        reg_rd,
    input logic [15:0] reg_rdata,
    input logic        burst_en,
    input logic        adc_nempty,
    input logic        adc_full,
    input logic        irq_req,
    input logic [15:0] lat_q,
    input logic [15:0] ev_vec,
    input logic        ext_rise
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[4:0] == 5'd0) && !reg_rdata[15]);

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=> ((lat_q & $past(reg_wdata & ~ev_vec) & STICKY_MASK) == 16'h0));

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_vec != 16'h0) |=> ((lat_q & $past(ev_vec)) == $past(ev_vec)));

    assert_single_edge_R4: assert property (@(posedge clk) disable iff (rst)
        ext_rise |=> !ext_rise);

    assert_burst_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (!burst_en && !lat_q[B_BURST]) |=> !lat_q[B_BURST]);

    assert_live_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_sel) |=> (reg_rdata[13:12] == $past({adc_full, adc_nempty})));

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !reg_wr) |=> irq_req);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_status_reg irq_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .burst_en   (burst_en),
    .adc_nempty (adc_nempty),
    .adc_full   (adc_full),
    .irq_req    (irq_req),
    .lat_q      (lat_q),
    .ev_vec     (ev_vec),
    .ext_rise   (ext_rise)
);

// File: tb/irq_status_reg_bench.sv
module irq_status_reg_bench;
    localparam int CNT_W = 10;
    localparam logic [15:0] STICKY = 16'h4FE0;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic             burst_en = 1'b0;
    logic [1:0]       gen_sel = '0, gen_src = '0;
    logic             ev_dac_half = 0, ev_acq_done = 0, ev_burst_done = 0;
    logic             ev_adc_nempty = 0, ev_dac_empty = 0, ext_irq_in = 0;
    logic [CNT_W-1:0] adc_level = '0;
    logic             adc_nempty = 0, adc_full = 0;
    logic             irq_req;

    int n_chk = 0, n_fail = 0;
    logic [15:0] exp_lat = '0, exp_mask = '0, rv;

    always #4 clk = ~clk;

    irq_status_reg u_irq_status_reg (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .burst_en(burst_en), .gen_sel(gen_sel), .gen_src(gen_src),
        .ev_dac_half(ev_dac_half), .ev_acq_done(ev_acq_done),
        .ev_burst_done(ev_burst_done), .ev_adc_nempty(ev_adc_nempty),
        .ev_dac_empty(ev_dac_empty), .ext_irq_in(ext_irq_in),
        .adc_level(adc_level), .adc_nempty(adc_nempty), .adc_full(adc_full),
        .irq_req(irq_req)
    );

    function automatic logic gen_model(input logic [1:0] s, input logic [1:0] src);
        case (s)
            2'd1:    return src[0];
            2'd2:    return src[1];
            2'd3:    return src[0] | src[1];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] ev_model(input logic dh, ad, bd, be, ne, de,
                                             input logic [1:0] s, src,
                                             input logic [CNT_W-1:0] lvl);
        logic [15:0] e = '0;
        e[5]  = dh;
        e[6]  = ad;
        e[7]  = gen_model(s, src);
        e[9]  = bd & be;
        e[10] = (lvl > CNT_W'(255));
        e[11] = ne;
        e[14] = de;
        return e;
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk); reg_rd = 1'b0; reg_sel = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic fire(input logic dh, ad, bd, ne, de, input logic [1:0] src);
        @(negedge clk);
        ev_dac_half = dh; ev_acq_done = ad; ev_burst_done = bd;
        ev_adc_nempty = ne; ev_dac_empty = de; gen_src = src;
        @(negedge clk);
        ev_dac_half = 0; ev_acq_done = 0; ev_burst_done = 0;
        ev_adc_nempty = 0; ev_dac_empty = 0; gen_src = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1A7C));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        check("R10 rdata after reset", reg_rdata, 16'h0);
        check("R10 irq after reset", {15'd0, irq_req}, 16'h0);
        rd(1'b0, rv); check("R10 status after reset", rv, 16'h0);
        rd(1'b1, rv); check("R10 mask after reset", rv, 16'h0);

        // R1: single sources land on their own bit
        fire(1, 0, 0, 0, 0, 2'b00); rd(0, rv); check("R1 DAC half bit5", rv, 16'h0020); wr(0, 16'hFFFF);
        fire(0, 1, 0, 0, 0, 2'b00); rd(0, rv); check("R1 acq done bit6", rv, 16'h0040); wr(0, 16'hFFFF);
        fire(0, 0, 0, 1, 0, 2'b00); rd(0, rv); check("R1 ne event bit11", rv, 16'h0800); wr(0, 16'hFFFF);
        fire(0, 0, 0, 0, 1, 2'b00); rd(0, rv); check("R1 DAC empty bit14", rv, 16'h4000); wr(0, 16'hFFFF);

        // R5: burst gating
        burst_en = 0; fire(0, 0, 1, 0, 0, 2'b00); rd(0, rv); check("R5 eob ignored w/o burst", rv, 16'h0000);
        burst_en = 1; fire(0, 0, 1, 0, 0, 2'b00); rd(0, rv); check("R5 eob in burst bit9", rv, 16'h0200);
        wr(0, 16'hFFFF); burst_en = 0;

        // R7: general select
        gen_sel = 2'd0; fire(0, 0, 0, 0, 0, 2'b11); rd(0, rv); check("R7 sel0 none", rv, 16'h0000);
        gen_sel = 2'd1; fire(0, 0, 0, 0, 0, 2'b10); rd(0, rv); check("R7 sel1 ignores src1", rv, 16'h0000);
        gen_sel = 2'd1; fire(0, 0, 0, 0, 0, 2'b01); rd(0, rv); check("R7 sel1 src0", rv, 16'h0080); wr(0, 16'hFFFF);
        gen_sel = 2'd2; fire(0, 0, 0, 0, 0, 2'b01); rd(0, rv); check("R7 sel2 ignores src0", rv, 16'h0000);
        gen_sel = 2'd2; fire(0, 0, 0, 0, 0, 2'b10); rd(0, rv); check("R7 sel2 src1", rv, 16'h0080); wr(0, 16'hFFFF);
        gen_sel = 2'd3; fire(0, 0, 0, 0, 0, 2'b10); rd(0, rv); check("R7 sel3 either", rv, 16'h0080); wr(0, 16'hFFFF);
        gen_sel = 2'd0;

        // R2: selective clear, zero write no effect
        fire(1, 1, 0, 1, 1, 2'b00);
        wr(0, 16'h0040); rd(0, rv); check("R2 clear only bit6", rv, 16'h4820);
        wr(0, 16'h0000); rd(0, rv); check("R2 zero write no effect", rv, 16'h4820);
        wr(0, 16'h4800); rd(0, rv); check("R2 clear bits 11,14", rv, 16'h0020);
        wr(0, 16'hFFFF);

        // R3: set and clear in the same cycle
        @(negedge clk); ev_acq_done = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0040;
        @(negedge clk); ev_acq_done = 0; reg_wr = 0; reg_wdata = '0;
        rd(0, rv); check("R3 set wins over clear", rv, 16'h0040); wr(0, 16'hFFFF);

        // R4: external edge
        @(negedge clk); ext_irq_in = 1;
        @(negedge clk); rv = 16'h0;
        rd(0, rv); check("R4 not yet through sync", rv & 16'h0100, 16'h0000);
        repeat (3) @(negedge clk);
        rd(0, rv); check("R4 rising edge latched", rv, 16'h0100);
        wr(0, 16'h0100); repeat (5) @(negedge clk);
        rd(0, rv); check("R4 steady high no relatch", rv, 16'h0000);
        ext_irq_in = 0; repeat (5) @(negedge clk);
        rd(0, rv); check("R4 falling edge ignored", rv, 16'h0000);
        ext_irq_in = 1; repeat (5) @(negedge clk);
        rd(0, rv); check("R4 second rise latched", rv, 16'h0100);
        ext_irq_in = 0; wr(0, 16'hFFFF); repeat (4) @(negedge clk);

        // R6: half-full threshold
        @(negedge clk); adc_level = 10'd255; repeat (3) @(negedge clk);
        rd(0, rv); check("R6 level 255 no set", rv, 16'h0000);
        adc_level = 10'd256; repeat (2) @(negedge clk);
        rd(0, rv); check("R6 level 256 sets bit10", rv, 16'h0400);
        wr(0, 16'h0400); rd(0, rv); check("R6 stays while above", rv, 16'h0400);
        adc_level = 10'd0; wr(0, 16'h0400); rd(0, rv); check("R6 cleared below", rv, 16'h0000);

        // R8: live flags
        @(negedge clk); adc_nempty = 1; adc_full = 1;
        wr(0, 16'hFFFF); rd(0, rv); check("R8 live flags survive clear", rv, 16'h3000);
        adc_full = 0; rd(0, rv); check("R8 live full follows", rv, 16'h1000);
        adc_nempty = 0; rd(0, rv); check("R8 live ne follows", rv, 16'h0000);

        // R9: enable mask and request
        wr(1, 16'hFFFF); rd(1, rv); check("R9 mask readback sticky only", rv, STICKY);
        wr(1, 16'h0020); rd(1, rv); check("R9 mask readback", rv, 16'h0020);
        fire(0, 1, 0, 0, 0, 2'b00); @(negedge clk);
        check("R9 masked source no irq", {15'd0, irq_req}, 16'h0);
        fire(1, 0, 0, 0, 0, 2'b00); @(negedge clk);
        check("R9 enabled source irq", {15'd0, irq_req}, 16'h1);
        wr(0, 16'h0020); @(negedge clk);
        check("R9 irq drops after clear", {15'd0, irq_req}, 16'h0);

        // R11: read data hold
        rd(0, rv); check("R11 read after clear", rv, 16'h0040);
        fire(1, 0, 0, 0, 1, 2'b00); repeat (2) @(negedge clk);
        check("R11 rdata holds w/o read", reg_rdata, 16'h0040);
        wr(0, 16'hFFFF);
        exp_lat = '0;

        // Random phase (R1 R2 R3 R5 R6 R7 R8 R9)
        exp_mask = 16'($urandom) & STICKY;
        wr(1, exp_mask);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            logic [15:0] ev, clr;
            if (i == 150) begin
                exp_mask = 16'($urandom) & STICKY;
                wr(1, exp_mask);
            end
            r = $urandom;
            @(negedge clk);
            ev_dac_half = r[0]; ev_acq_done = r[1]; ev_burst_done = r[2];
            burst_en = r[3]; gen_src = r[5:4]; gen_sel = r[7:6];
            ev_adc_nempty = r[8]; ev_dac_empty = r[9];
            adc_nempty = r[10]; adc_full = r[11];
            adc_level = CNT_W'($urandom_range(240, 272));
            clr = 16'h0;
            if (r[12]) begin
                clr = 16'($urandom);
                reg_wr = 1; reg_sel = 0; reg_wdata = clr;
            end
            ev = ev_model(r[0], r[1], r[2], r[3], r[8], r[9], r[7:6], r[5:4], adc_level);
            exp_lat = ev | (exp_lat & ~(clr & STICKY));
            @(negedge clk);
            ev_dac_half = 0; ev_acq_done = 0; ev_burst_done = 0;
            ev_adc_nempty = 0; ev_dac_empty = 0; gen_src = '0;
            reg_wr = 0; reg_wdata = '0; reg_rd = 1; reg_sel = 0;
            @(negedge clk);
            reg_rd = 0;
            check("R1 R2 R3 random status", reg_rdata, exp_lat | {2'b00, adc_full, adc_nempty, 12'h0});
            check("R9 random irq", {15'd0, irq_req}, {15'd0, |(exp_lat & exp_mask)});
        end

        report();
        $finish;
    end
endmodule